// File: doc/BRIEF.md
# Pushbutton Press Conditioner

This block turns a raw mechanical pushbutton line into a single, short request pulse in the system clock domain, so that one press starts exactly one downstream action such as a serial transmission. The raw line is first brought into the clock domain through a flop chain. A free-running divider then produces a one-cycle enable once every `CLK_DIV` clocks; with the default of one million on a 100 MHz clock, that is a 100 Hz sampling rate. The button is looked at only on those enables, so contact bounce faster than the sampling period cannot be seen.

A press counts only when two successive samples both read high. After a press has fired, the block stays quiet until a sample reads the button released. It starts in that same waiting condition after reset, so a button held through reset does nothing until it has been let go. Each accepted press produces a pulse of exactly `PULSE_LEN` clocks. That length is at most three clocks, however long the button is held.

Top module: `btn_pulse_conditioner`

## Requirements
- R1: While `rst_n` is low, `pulse_o` is low, and it drops low at once when reset is asserted, even in the middle of a pulse.
- R2: The button is sampled once every `CLK_DIV` clocks after a two-stage synchronizer. With two sync stages, a clean press whose raw line rises just before clock edge 1 gives a first high `pulse_o` after edge n, where n lies between `CLK_DIV`+4 and 2*`CLK_DIV`+3 inclusive.
- R3: Every pulse is high for exactly `PULSE_LEN` consecutive clocks (3 by default) and never longer than 3 clocks.
- R4: One press yields exactly one pulse, however long the button stays held.
- R5: A high interval on the raw line lasting no more than `CLK_DIV` clocks never yields a pulse, because acceptance needs two consecutive high samples.
- R6: After a pulse, and after reset, no pulse fires until a sample has read the button low. A button held through reset release gives no pulse until it has been released and pressed again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| btn_raw_i | input | 1 | Raw pushbutton level, asynchronous to `clk`, high when pressed |
| pulse_o | output | 1 | Request pulse, `PULSE_LEN` clocks wide per accepted press |

## Verification
A press produces its first pulse cycle no earlier than `CLK_DIV`+4 and no later than 2*`CLK_DIV`+3 edges after the raw line rises. That window comes from two sync flops, two sampling enables, the registered accept flag and the registered pulse counter. The bench stamps the cycle on which it raises the line, samples `pulse_o` on falling edges, and checks the rise against that window only for clean presses. After bounced presses it checks the pulse count and the width of each pulse. Every stimulus is followed by at least three sampling periods of released button before the count is compared, so a late pulse is still counted against the right press. The reset checks look at `pulse_o` one nanosecond after `rst_n` falls.

// File: rtl/pb_pkg.sv
package pb_pkg;

  typedef enum logic [1:0] {
    PF_WAIT_REL = 2'd0,
    PF_ARMED    = 2'd1,
    PF_HALF     = 2'd2
  } pf_state_e;

  function automatic int cnt_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/pb_sync.sv
module pb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sr_d = d_i;
    end else begin : g_chain
      always_comb sr_d = {sr_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/pb_tick_gen.sv
module pb_tick_gen
  import pb_pkg::*;
#(
  parameter int CLK_DIV = 1_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = cnt_width(CLK_DIV);
  localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    tick_o = (cnt_q == LAST);
    cnt_d  = tick_o ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pb_press_filter.sv
module pb_press_filter
  import pb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic btn_i,
  output logic fire_o
);
  pf_state_e state_q, state_d;
  logic      fire_q, fire_d;

  always_comb begin
    state_d = state_q;
    fire_d  = 1'b0;
    if (tick_i) begin
      unique case (state_q)
        PF_WAIT_REL: if (!btn_i) state_d = PF_ARMED;
        PF_ARMED:    if (btn_i)  state_d = PF_HALF;
        PF_HALF: begin
          if (btn_i) begin
            state_d = PF_WAIT_REL;
            fire_d  = 1'b1;
          end else begin
            state_d = PF_ARMED;
          end
        end
        default:     state_d = PF_WAIT_REL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PF_WAIT_REL;
      fire_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      fire_q  <= fire_d;
    end
  end

  assign fire_o = fire_q;
endmodule

// File: rtl/pb_pulse_shaper.sv
module pb_pulse_shaper #(
  parameter int PULSE_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic pulse_o
);
  localparam int CW = $clog2(PULSE_LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_LEN);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    if (fire_i)              cnt_d = LOAD;
    else if (cnt_q != '0)    cnt_d = cnt_q - CW'(1);
    else                     cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign pulse_o = (cnt_q != '0);
endmodule

// File: rtl/btn_pulse_conditioner.sv
module btn_pulse_conditioner #(
  parameter int CLK_DIV     = 1_000_000,
  parameter int SYNC_STAGES = 2,
  parameter int PULSE_LEN   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_raw_i,
  output logic pulse_o
);
  logic btn_sync;
  logic tick_en;
  logic press_fire;

  pb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (btn_raw_i),
    .q_o   (btn_sync)
  );

  pb_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick_en)
  );

  pb_press_filter u_filter (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_en),
    .btn_i  (btn_sync),
    .fire_o (press_fire)
  );

  pb_pulse_shaper #(.PULSE_LEN(PULSE_LEN)) u_shaper (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire_i  (press_fire),
    .pulse_o (pulse_o)
  );
endmodule

// File: rtl/pb_checker.sv
module pb_checker #(
  parameter int CLK_DIV   = 1_000_000,
  parameter int PULSE_LEN = 3
) (
  input logic clk,
  input logic rst_n,
  input logic tick_en,
  input logic btn_sync,
  input logic press_fire,
  input logic pulse_o
);
  logic [7:0]  run_cnt;
  int unsigned gap_cnt;
  logic        seen_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt  <= '0;
      gap_cnt  <= 0;
      seen_low <= 1'b0;
    end else begin
      if (!pulse_o)               run_cnt <= '0;
      else if (run_cnt != 8'hFF)  run_cnt <= run_cnt + 8'd1;
      gap_cnt <= tick_en ? 0 : gap_cnt + 1;
      if (tick_en && !btn_sync)   seen_low <= 1'b1;
      else if (press_fire)        seen_low <= 1'b0;
    end
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |-> (gap_cnt == CLK_DIV - 1)); // R2

  AST_PULSE_WIDTH_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> (run_cnt < 8'(PULSE_LEN)) && (run_cnt < 8'd3)); // R3

  AST_PULSE_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> $past(press_fire)); // R4

  AST_ACCEPT_ON_HIGH_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    press_fire |-> ($past(tick_en) && $past(btn_sync))); // R5

  AST_REARM_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    press_fire |-> seen_low); // R6
endmodule

bind btn_pulse_conditioner pb_checker #(
  .CLK_DIV   (CLK_DIV),
  .PULSE_LEN (PULSE_LEN)
) u_chk (.*);

// File: tb/btn_pulse_conditioner_bench.sv
`timescale 1ns/1ps
module btn_pulse_conditioner_bench;
  localparam int DIV  = 16;
  localparam int PLEN = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn_raw = 1'b0;
  logic pulse;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int rises = 0;
  int run_len = 0;
  int last_rise = 0;
  logic prev = 1'b0;

  btn_pulse_conditioner #(.CLK_DIV(DIV), .SYNC_STAGES(2), .PULSE_LEN(PLEN)) u_btn_pulse_conditioner (
    .clk       (clk),
    .rst_n     (rst_n),
    .btn_raw_i (btn_raw),
    .pulse_o   (pulse)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit lat_ok(input int n);
    return (n >= DIV + 4) && (n <= 2 * DIV + 3);
  endfunction

  // width monitor, sampled on falling edges
  always @(negedge clk) begin
    if (!rst_n) begin
      run_len = 0;
      prev    = 1'b0;
    end else begin
      if (pulse && !prev) begin
        rises++;
        last_rise = cyc;
      end
      if (pulse) run_len++;
      else if (prev) begin
        check(run_len == PLEN, "R3 width", run_len, PLEN);
        run_len = 0;
      end
      prev = pulse;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clean_press(input int hold, input bit chk_lat, input string tag);
    int p, r0;
    @(negedge clk);
    r0 = rises;
    btn_raw = 1'b1;
    p = cyc;
    wait_cyc(hold);
    btn_raw = 1'b0;
    wait_cyc(3 * DIV);
    check(rises - r0 == 1, tag, rises - r0, 1);
    if (chk_lat) check(lat_ok(last_rise - p), "R2 latency", last_rise - p, DIV + 4);
  endtask

  task automatic short_high(input int len);
    int r0;
    @(negedge clk);
    r0 = rises;
    btn_raw = 1'b1;
    wait_cyc(len);
    btn_raw = 1'b0;
    wait_cyc(3 * DIV);
    check(rises == r0, "R5 short high ignored", rises - r0, 0);
  endtask

  task automatic bounce_burst(input bit end_high);
    int nb;
    nb = int'($urandom_range(5, 1));
    for (int i = 0; i < nb; i++) begin
      btn_raw = 1'b1;
      wait_cyc(int'($urandom_range(DIV, 1)));
      btn_raw = 1'b0;
      wait_cyc(int'($urandom_range(2 * DIV, DIV)));
    end
    btn_raw = end_high;
  endtask

  task automatic bounced_press();
    int r0;
    @(negedge clk);
    r0 = rises;
    bounce_burst(1'b1);
    wait_cyc(int'($urandom_range(6 * DIV, 3 * DIV)));
    btn_raw = 1'b0;
    wait_cyc(int'($urandom_range(2 * DIV, DIV)));
    bounce_burst(1'b0);
    wait_cyc(3 * DIV);
    check(rises - r0 == 1, "R4 R5 bounced press", rises - r0, 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : main
    int r0;
    void'($urandom(32'd4711));
    // R1: reset state
    wait_cyc(3);
    check(pulse == 1'b0, "R1 reset low", pulse, 0);
    // R6: button held through reset release
    btn_raw = 1'b1;
    wait_cyc(2);
    rst_n = 1'b1;
    r0 = rises;
    wait_cyc(6 * DIV);
    check(rises == r0, "R6 held through reset", rises - r0, 0);
    check(pulse == 1'b0, "R6 output low while held", pulse, 0);
    btn_raw = 1'b0;
    wait_cyc(3 * DIV);
    check(rises == r0, "R6 release alone", rises - r0, 0);
    clean_press(3 * DIV, 1'b1, "R6 first press after release");
    // R2 / R4 directed
    clean_press(3 * DIV, 1'b1, "R4 clean press");
    clean_press(20 * DIV, 1'b1, "R4 long hold single pulse");
    clean_press(2 * DIV, 1'b0, "R5 two-period hold accepted");
    // R5 boundaries
    short_high(1);
    short_high(DIV);
    short_high(DIV / 2);
    // R1: asynchronous reset mid-pulse
    @(negedge clk);
    btn_raw = 1'b1;
    for (int i = 0; i < 3 * DIV && !pulse; i++) @(negedge clk);
    check(pulse == 1'b1, "R1 pulse before reset", pulse, 1);
    #1 rst_n = 1'b0;
    #1 check(pulse == 1'b0, "R1 async clear", pulse, 0);
    btn_raw = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(3 * DIV);
    // random clean presses and bounced presses
    for (int k = 0; k < 12; k++)
      clean_press(int'($urandom_range(8 * DIV, 3 * DIV)), 1'b1, "R2 R4 random press");
    for (int k = 0; k < 20; k++) bounced_press();
    for (int k = 0; k < 8; k++) short_high(int'($urandom_range(DIV, 1)));
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule